// File: doc/BRIEF.md
# Configurable Single-Port Block RAM

This block is a synthesizable model of a single-port synchronous RAM whose data store is always 16384 bits. The word shape is picked by the `WIDTH` parameter from 1, 2, 4, 9, 18 or 36 bits. The 9-, 18- and 36-bit shapes split each word into byte lanes plus one extra bit per byte. These extra bits live in a separate 2048-bit store and travel on their own input and output ports. Depth and address width follow from the shape: 16384x1 (14 address bits), 8192x2 (13), 4096x4 (12), 2048x(8+1) (11), 1024x(16+2) (10) and 512x(32+4) (9).

Every action happens on the rising clock edge and all controls are active high. A registered output presents read data. That register can also be forced to a chosen reset pattern, and it starts from a separately chosen power-on pattern. The behaviour of the output during a write is a build-time choice: it can show the new word, show the word being replaced, or stay as it was. Memory contents can be preloaded from two wide parameters, one for data and one for the extra bits, and both default to zero.

Top module: `cfg_sp_ram`

## Requirements
- R1: Depth and address width follow `WIDTH` as 16384/data-width words with log2(depth) address bits. The lowest address and the highest address (depth-1) hold separate words, and addresses wider than the port are never decoded.
- R2: With `en` low, nothing is written, and both `rdata` and `rpar` keep their values whatever `we`, `srst`, `addr` or the inputs do.
- R3: On an edge with `en` and `srst` high, `{rpar,rdata}` loads the low `WIDTH` bits of `SRST_VAL`. If `we` is also high, the addressed word is still written from `wdata`/`wpar` on that edge.
- R4: On an edge with `en` high and both `srst` and `we` low, the word at `addr` moves into the output register. A read after a write to the same address returns the written word.
- R5: In write-first mode (`WMODE` = `WM_WRITE_FIRST`, encoding 0, the default), a write presents the incoming `{wpar,wdata}` on the outputs after the same edge.
- R6: In read-first mode (`WM_READ_FIRST`, encoding 1), a write presents the previous contents of the addressed word on the outputs and stores the input.
- R7: In no-change mode (`WM_NO_CHANGE`, encoding 2), a write stores the input and leaves `rdata` and `rpar` unchanged.
- R8: Before the first edge, `{rpar,rdata}` equals the low `WIDTH` bits of `PWRON_VAL`. In both `PWRON_VAL` and `SRST_VAL` the extra bits sit at the most significant positions, bits `WIDTH-1` down to the data width. Both values default to zero.
- R9: Word i starts with data `PRELOAD_DATA[i*DW +: DW]` and extra bits `PRELOAD_PAR[i*PW +: PW]`. A shorter preload literal is zero-extended on the left, so words it does not reach read as zero.
- R10: In the 1-, 2- and 4-bit shapes there is no extra-bit store. `rpar` is one bit wide and always 0, and `wpar` has no effect on stored data.
- R11: A `WIDTH` outside the six legal shapes, or a `WMODE` outside the three encodings, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| en | input | 1 | Port enable; gates reads, writes and output reset |
| we | input | 1 | Write enable |
| srst | input | 1 | Synchronous output-register reset to `SRST_VAL` |
| addr | input | log2(16384/DW) | Word address |
| wdata | input | DW | Write data (WIDTH minus extra bits) |
| wpar | input | max(PW,1) | Extra bits to write (PW = WIDTH/9 for 9/18/36, else unused) |
| rdata | output | DW | Registered read data |
| rpar | output | max(PW,1) | Registered extra bits (0 when the shape has none) |

## Verification
Two events can land on the same edge: an output reset and a write, and separately a write and the output update chosen by the write mode. The bench drives `srst` and `we` high together and then reads the address back. This shows that the output took the reset pattern while the memory still took the new word. Three instances run side by side, each in a different write mode and shape, under random traffic that favours a few colliding addresses. Each output is judged against a bench model that applies the order reset, then read, then mode-dependent write, and this is checked after every edge.

// File: rtl/cfg_sp_ram_pkg.sv
package cfg_sp_ram_pkg;

   localparam int unsigned DATA_CAP = 16384;
   localparam int unsigned PAR_CAP  = 2048;

   typedef enum logic [1:0] {
      WM_WRITE_FIRST = 2'd0,
      WM_READ_FIRST  = 2'd1,
      WM_NO_CHANGE   = 2'd2
   } wmode_e;

   function automatic bit legal_width(int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   // extra (per-byte) bits per word
   function automatic int unsigned par_w(int unsigned w);
      return (w >= 9) ? (w / 9) : 0;
   endfunction

   function automatic int unsigned data_w(int unsigned w);
      return (w > par_w(w)) ? (w - par_w(w)) : 1;
   endfunction

   function automatic int unsigned depth_of(int unsigned w);
      return DATA_CAP / data_w(w);
   endfunction

   function automatic int unsigned addr_w(int unsigned w);
      return $clog2(depth_of(w));
   endfunction

   function automatic int unsigned port_par_w(int unsigned w);
      return (par_w(w) == 0) ? 1 : par_w(w);
   endfunction

endpackage

// File: rtl/cfg_sp_ram_store.sv
module cfg_sp_ram_store #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned W     = 32,
   parameter logic [DEPTH*W-1:0] PRELOAD = '0,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = PRELOAD[i*W +: W];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= wdata;
      end
   end

   // pre-write contents of the addressed word
   assign rdata = mem[addr];

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R4: a written word is what the same address reads next cycle
   a_r4_write_lands: assert property (@(posedge clk) disable iff (!armed)
      wr_en |=> (addr != $past(addr)) || (rdata == $past(wdata)));

endmodule

// File: rtl/cfg_sp_ram_outreg.sv
module cfg_sp_ram_outreg
   import cfg_sp_ram_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter wmode_e      WMODE = WM_WRITE_FIRST,
   parameter logic [W-1:0] PWR  = '0,
   parameter logic [W-1:0] RST  = '0
) (
   input  logic         clk,
   input  logic         en,
   input  logic         we,
   input  logic         srst,
   input  logic [W-1:0] wdat,
   input  logic [W-1:0] old,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r = PWR;
   logic [W-1:0] wr_next;
   logic         wr_load;

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // write-cycle output source picked by the mode
   if (WMODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_next = wdat;
      assign wr_load = 1'b1;
      a_r5_shows_new: assert property (@(posedge clk) disable iff (!armed)
         (en && we && !srst) |=> (q == $past(wdat)));
   end else if (WMODE == WM_READ_FIRST) begin : g_rf
      assign wr_next = old;
      assign wr_load = 1'b1;
      a_r6_shows_old: assert property (@(posedge clk) disable iff (!armed)
         (en && we && !srst) |=> (q == $past(old)));
   end else begin : g_nc
      assign wr_next = q_r;
      assign wr_load = 1'b0;
      a_r7_holds_on_write: assert property (@(posedge clk) disable iff (!armed)
         (en && we && !srst) |=> $stable(q));
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (srst) begin
            q_r <= RST;
         end else if (!we) begin
            q_r <= old;
         end else if (wr_load) begin
            q_r <= wr_next;
         end
      end
   end

   assign q = q_r;

   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!armed)
      !en |=> $stable(q));

   a_r3_reset_value: assert property (@(posedge clk) disable iff (!armed)
      (en && srst) |=> (q == RST));

   a_r4_read_word: assert property (@(posedge clk) disable iff (!armed)
      (en && !srst && !we) |=> (q == $past(old)));

endmodule

// File: rtl/cfg_sp_ram.sv
module cfg_sp_ram
   import cfg_sp_ram_pkg::*;
#(
   parameter int unsigned WIDTH = 36,
   parameter wmode_e      WMODE = WM_WRITE_FIRST,
   parameter logic [35:0] PWRON_VAL = '0,
   parameter logic [35:0] SRST_VAL  = '0,
   parameter logic [DATA_CAP-1:0] PRELOAD_DATA = '0,
   parameter logic [PAR_CAP-1:0]  PRELOAD_PAR  = '0,
   localparam int unsigned DW    = data_w(WIDTH),
   localparam int unsigned PW    = par_w(WIDTH),
   localparam int unsigned PPW   = port_par_w(WIDTH),
   localparam int unsigned DEPTH = depth_of(WIDTH),
   localparam int unsigned AW    = addr_w(WIDTH)
) (
   input  logic           clk,
   input  logic           en,
   input  logic           we,
   input  logic           srst,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   input  logic [PPW-1:0] wpar,
   output logic [DW-1:0]  rdata,
   output logic [PPW-1:0] rpar
);

   // R11: elaboration-time legality checks
   if (!legal_width(WIDTH)) begin : g_bad_width
      $error("cfg_sp_ram: WIDTH %0d is not one of 1,2,4,9,18,36", WIDTH);
   end
   if ((WMODE != WM_WRITE_FIRST) && (WMODE != WM_READ_FIRST) && (WMODE != WM_NO_CHANGE)) begin : g_bad_mode
      $error("cfg_sp_ram: unknown write mode");
   end
   if (DW * DEPTH != DATA_CAP) begin : g_bad_geom
      $error("cfg_sp_ram: data plane does not fill the store");
   end

   logic          wr_en;
   logic [DW-1:0] d_old;

   assign wr_en = en && we;

   cfg_sp_ram_store #(
      .DEPTH   (DEPTH),
      .W       (DW),
      .PRELOAD (PRELOAD_DATA[DEPTH*DW-1:0])
   ) u_dstore (
      .clk   (clk),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (d_old)
   );

   cfg_sp_ram_outreg #(
      .W     (DW),
      .WMODE (WMODE),
      .PWR   (PWRON_VAL[DW-1:0]),
      .RST   (SRST_VAL[DW-1:0])
   ) u_dout (
      .clk  (clk),
      .en   (en),
      .we   (we),
      .srst (srst),
      .wdat (wdata),
      .old  (d_old),
      .q    (rdata)
   );

   if (PW > 0) begin : g_par
      // extra bits occupy the top of the reset and power-on values
      if (DEPTH * PW != PAR_CAP) begin : g_bad_par
         $error("cfg_sp_ram: parity plane does not fill its store");
      end

      logic [PW-1:0] p_old;

      cfg_sp_ram_store #(
         .DEPTH   (DEPTH),
         .W       (PW),
         .PRELOAD (PRELOAD_PAR[DEPTH*PW-1:0])
      ) u_pstore (
         .clk   (clk),
         .wr_en (wr_en),
         .addr  (addr),
         .wdata (wpar),
         .rdata (p_old)
      );

      cfg_sp_ram_outreg #(
         .W     (PW),
         .WMODE (WMODE),
         .PWR   (PWRON_VAL[WIDTH-1 -: PW]),
         .RST   (SRST_VAL[WIDTH-1 -: PW])
      ) u_pout (
         .clk  (clk),
         .en   (en),
         .we   (we),
         .srst (srst),
         .wdat (wpar),
         .old  (p_old),
         .q    (rpar)
      );
   end else begin : g_nopar
      // R10: no extra-bit store in narrow shapes
      assign rpar = '0;
   end

endmodule

// File: tb/cfg_sp_ram_tb.sv
module cfg_sp_ram_tb;
   import cfg_sp_ram_pkg::*;

   localparam int CLK_PERIOD = 10;

   localparam logic [35:0] PWR_A = 36'h9_1234_5678;
   localparam logic [35:0] RST_A = 36'hA_CAFE_F00D;
   localparam logic [35:0] PWR_B = 36'h155;
   localparam logic [35:0] RST_B = 36'h0AA;
   localparam logic [35:0] PWR_C = 36'h6;
   localparam logic [35:0] RST_C = 36'h9;

   logic        clk = 1'b0;
   logic        en = 1'b0, we = 1'b0, srst = 1'b0;
   logic [13:0] addr = '0;
   logic [35:0] din = '0;

   logic [31:0] rdA;  logic [3:0] rpA;
   logic [7:0]  rdB;  logic       rpB;
   logic [3:0]  rdC;  logic       rpC;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // 36-bit shape, write-first, with preload
   cfg_sp_ram #(
      .WIDTH (36), .WMODE (WM_WRITE_FIRST),
      .PWRON_VAL (PWR_A), .SRST_VAL (RST_A),
      .PRELOAD_DATA (16384'h1111_2222_3333_4444),
      .PRELOAD_PAR  (2048'hC5)
   ) u_dut (
      .clk (clk), .en (en), .we (we), .srst (srst), .addr (addr[8:0]),
      .wdata (din[31:0]), .wpar (din[35:32]), .rdata (rdA), .rpar (rpA)
   );

   // 9-bit shape, read-first
   cfg_sp_ram #(
      .WIDTH (9), .WMODE (WM_READ_FIRST),
      .PWRON_VAL (PWR_B), .SRST_VAL (RST_B)
   ) u_rf (
      .clk (clk), .en (en), .we (we), .srst (srst), .addr (addr[10:0]),
      .wdata (din[7:0]), .wpar (din[8]), .rdata (rdB), .rpar (rpB)
   );

   // 4-bit shape, no-change, no extra bits
   cfg_sp_ram #(
      .WIDTH (4), .WMODE (WM_NO_CHANGE),
      .PWRON_VAL (PWR_C), .SRST_VAL (RST_C)
   ) u_nc (
      .clk (clk), .en (en), .we (we), .srst (srst), .addr (addr[11:0]),
      .wdata (din[3:0]), .wpar (din[35]), .rdata (rdC), .rpar (rpC)
   );

   // bench model
   logic [35:0] mA [512];
   logic [35:0] mB [2048];
   logic [35:0] mC [4096];
   logic [35:0] eA = PWR_A;
   logic [35:0] eB = PWR_B;
   logic [35:0] eC = PWR_C;

   function automatic logic [35:0] nxt(int mode, logic [35:0] q, logic [35:0] old,
                                       logic [35:0] d, logic e, logic w, logic s,
                                       logic [35:0] rst);
      if (!e) return q;
      if (s) return rst;
      if (!w) return old;
      case (mode)
         0: return d;
         1: return old;
         default: return q;
      endcase
   endfunction

   function automatic string tag_of(logic e, logic w, logic s, int mode);
      if (!e) return "R2";
      if (s) return "R3";
      if (!w) return "R4";
      case (mode)
         0: return "R5";
         1: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, string who, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, who, act, exp, $time);
      end
   endtask

   task automatic step(logic e, logic w, logic s, logic [13:0] a, logic [35:0] d, string ovr);
      logic [35:0] oA, oB, oC, wB, wC;
      @(negedge clk);
      en = e; we = w; srst = s; addr = a; din = d;
      @(posedge clk);
      #1;
      wB = {27'b0, d[8:0]};
      wC = {32'b0, d[3:0]};
      oA = mA[a[8:0]];
      oB = mB[a[10:0]];
      oC = mC[a[11:0]];
      eA = nxt(0, eA, oA, d, e, w, s, RST_A);
      eB = nxt(1, eB, oB, wB, e, w, s, RST_B);
      eC = nxt(2, eC, oC, wC, e, w, s, RST_C);
      if (e && w) begin
         mA[a[8:0]]   = d;
         mB[a[10:0]]  = wB;
         mC[a[11:0]]  = wC;
      end
      check((ovr == "") ? tag_of(e, w, s, 0) : ovr, "w36", {rpA, rdA}, eA);
      check((ovr == "") ? tag_of(e, w, s, 1) : ovr, "w9",  {27'b0, rpB, rdB}, eB);
      check((ovr == "") ? tag_of(e, w, s, 2) : ovr, "w4",  {32'b0, rdC}, eC);
      check("R10", "w4 rpar", {35'b0, rpC}, 36'h0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++)  mA[i] = '0;
      for (int i = 0; i < 2048; i++) mB[i] = '0;
      for (int i = 0; i < 4096; i++) mC[i] = '0;
      // R9: preload words 0 and 1, extra bits in the top nibble
      mA[0] = 36'h5_3333_4444;
      mA[1] = 36'hC_1111_2222;
   end

   initial begin
      void'($urandom(32'd7711));
      #1;
      // R8: power-on patterns before any edge
      check("R8", "w36", {rpA, rdA}, PWR_A);
      check("R8", "w9",  {27'b0, rpB, rdB}, PWR_B);
      check("R8", "w4",  {32'b0, rdC}, PWR_C);
      check("R10", "w4 rpar", {35'b0, rpC}, 36'h0);

      // R9: preloaded and unreached words
      step(1, 0, 0, 14'd0, '0, "R9");
      step(1, 0, 0, 14'd1, '0, "R9");
      step(1, 0, 0, 14'd2, '0, "R9");

      // R1: top and bottom addresses are separate words
      step(1, 1, 0, 14'd4095, 36'hF_DEAD_BEEF, "");
      step(1, 1, 0, 14'd0,    36'h3_0BAD_CAFE, "");
      step(1, 0, 0, 14'd4095, '0, "R1");
      step(1, 0, 0, 14'd0,    '0, "R1");

      // R3: reset and write on the same edge, then read back
      step(1, 1, 1, 14'd5, 36'h7_89AB_CDEF, "R3");
      step(1, 0, 0, 14'd5, '0, "R3");

      // R2: disabled write leaves memory and outputs alone
      step(0, 1, 1, 14'd5, 36'h1_1111_1111, "R2");
      step(0, 0, 0, 14'd6, '0, "R2");
      step(1, 0, 0, 14'd5, '0, "R2");

      // R10: extra-bit input has no effect in the 4-bit shape
      step(1, 1, 0, 14'd9, 36'h8_0000_0005, "R10");
      step(1, 0, 0, 14'd9, '0, "R10");

      // random traffic over a few colliding addresses
      for (int k = 0; k < 600; k++) begin
         logic [13:0] a;
         logic e, w, s;
         case ($urandom_range(0, 5))
            0: a = 14'd0;
            1: a = 14'd1;
            2: a = 14'd4095;
            3: a = 14'd2047;
            4: a = 14'd511;
            default: a = 14'($urandom_range(0, 16383));
         endcase
         e = ($urandom_range(0, 9) != 0);
         s = ($urandom_range(0, 6) == 0);
         w = ($urandom_range(0, 1) == 1);
         step(e, w, s, a, {$urandom(), $urandom()} >> 28, "");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule